// File: doc/BRIEF.md
# Instruction Format Predecoder

The block looks at one 32-bit instruction word and sorts it into one of four encoding families: control transfer, compare-and-branch, register-to-register, and memory. For each word it reports the family and whether the encoding is illegal. It gives the byte length of the instruction, 4 or 8, so that a fetch unit can step to the next word. It also splits out the operand-specifier fields onto separate ports, so that later stages can use them without re-slicing the word.

The decision is combinational. All results are captured in one output register stage when the input strobe is high, and a matching output strobe follows one cycle later. The results hold while no new word arrives. Four parameter bitmaps, one per family, say which opcodes are populated. An unpopulated opcode is reported as illegal.

Top module: `insn_predecode`

## Requirements
- R1: `fmtClass` is taken from inWord[31:28]: 0x0-0x1 gives 0 (control), 0x2-0x3 gives 1 (compare-and-branch), 0x4-0x7 gives 2 (register), and 0x8-0xF gives 3 (memory).
- R2: A control word is illegal when its bit 0 is set, or when bit inWord[28:24] of the control bitmap is 0. All of its operand fields, literal and specifier flags are 0, and `opcode` is {inWord[31:24], 4'h0}.
- R3: A compare-and-branch word is illegal when bit inWord[28:24] of its bitmap is 0. It gives `src1`=inWord[23:19], `src2`=inWord[18:14], `litM1`=inWord[13] and `specS2`=inWord[0]; `dst`, `litM2`, `litM3` and `specS1` are 0.
- R4: A register word has `opcode` = {inWord[31:24], inWord[10:7]}. It is legal only when that opcode lies in 0x580..0x79F and bit (opcode-0x580) of the register bitmap is 1.
- R5: A register word gives `src1`=inWord[4:0], `specS1`=bit 5, `specS2`=bit 6, `litM1`=bit 11, `litM2`=bit 12, `litM3`=bit 13, `src2`=inWord[18:14] and `dst`=inWord[23:19].
- R6: `lengthIs8` is 1 only for a memory word whose opcode is populated and whose mode inWord[13:10] is 5 or at least 12. Every other word, including a memory word with an unpopulated opcode, reports length 4.
- R7: A memory word is illegal when its mode is 6, or when bit inWord[30:24] of the memory bitmap is 0.
- R8: A memory word gives `memMode`=inWord[13:10], `src1`=inWord[4:0], `src2`=inWord[18:14] and `dst`=inWord[23:19]. `memShort` is 1 when mode bit 2 is clear, and then `memOffset`=inWord[11:0]; otherwise `memOffset` is 0. For other families these three ports are 0.
- R9: `hintNotTaken` equals inWord[1] for control and compare-and-branch words and is 0 for the other families.
- R10: `brDisp` is the sign-extended value {inWord[23:2],2'b00} for control words and {inWord[12:2],2'b00} for compare-and-branch words, and 0 otherwise.
- R11: Results appear, with `outValid` high, on the clock edge after an edge with `inValid` high. With `inValid` low, `outValid` goes low on the next edge and every result port holds its value.
- R12: After reset, `outValid` and every result port are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Word strobe |
| inWord | input | 32 | Instruction word |
| outValid | output | 1 | Results strobe, one cycle after inValid |
| fmtClass | output | 2 | Encoding family |
| lengthIs8 | output | 1 | Instruction is 8 bytes |
| invalid | output | 1 | Illegal or unpopulated encoding |
| opcode | output | 12 | Opcode, extended for register family |
| src1 | output | 5 | First source / index field |
| src2 | output | 5 | Second source / base field |
| dst | output | 5 | Destination field |
| litM1 | output | 1 | Mode flag M1 |
| litM2 | output | 1 | Mode flag M2 |
| litM3 | output | 1 | Mode flag M3 |
| specS1 | output | 1 | Specifier flag S1 |
| specS2 | output | 1 | Specifier flag S2 |
| hintNotTaken | output | 1 | Static branch-not-taken hint |
| memMode | output | 4 | Memory addressing mode |
| memShort | output | 1 | Short memory form |
| memOffset | output | 12 | Short-form offset |
| brDisp | output | 32 | Sign-extended branch displacement |

## Verification
Two things can be reported for the same word: a control word can be flagged illegal and still pass on its branch hint and displacement. A memory word can have a long-form mode and still be held at length 4 because its opcode is unpopulated. The sweep covers every opcode byte with all sixteen values of the mode or low-opcode nibble. The other bits are pseudo-random, so bit 0 and bit 1 of control words take every combination with populated and unpopulated opcodes. Each result port is compared separately with a value the bench works out from the requirements, so a coincidence that hides one result behind another shows up as a mismatch on that port.

// File: rtl/ipd_pkg.sv
package ipd_pkg;

  localparam int WORD_W   = 32;
  localparam int FIELD_W  = 5;
  localparam int OPC_W    = 12;
  localparam int OFFS_W   = 12;
  localparam int MODE_W   = 4;
  localparam int REG_LO   = 'h580;
  localparam int REG_HI   = 'h79F;
  localparam int REG_N    = REG_HI - REG_LO + 1;
  localparam int CTRL_N   = 32;
  localparam int COBR_N   = 32;
  localparam int MEM_N    = 128;

  localparam logic [CTRL_N-1:0] DEF_CTRL_POP = 32'hFF0F_0FFF;
  localparam logic [COBR_N-1:0] DEF_COBR_POP = 32'hFF7E_00FF;
  localparam logic [REG_N-1:0]  DEF_REG_POP  = {17{32'hF0F0_FFFF}};
  localparam logic [MEM_N-1:0]  DEF_MEM_POP  = {4{32'h5555_FFFF}};

  typedef enum logic [1:0] {
    FMT_CTRL = 2'd0,
    FMT_COBR = 2'd1,
    FMT_REG  = 2'd2,
    FMT_MEM  = 2'd3
  } fmt_e;

  typedef struct packed {
    logic load;
    logic validNext;
  } strobe_t;

  typedef struct packed {
    fmt_e               fmt;
    logic               len8;
    logic               bad;
    logic [OPC_W-1:0]   opc;
    logic [FIELD_W-1:0] src1;
    logic [FIELD_W-1:0] src2;
    logic [FIELD_W-1:0] dst;
    logic               m1;
    logic               m2;
    logic               m3;
    logic               s1;
    logic               s2;
    logic               hint;
    logic [MODE_W-1:0]  mode;
    logic               short;
    logic [OFFS_W-1:0]  offs;
    logic [WORD_W-1:0]  disp;
  } decode_t;

endpackage

// File: rtl/ipd_ctrl.sv
module ipd_ctrl
  import ipd_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  output strobe_t strobe,
  output logic    outValid
);

  always_comb begin
    strobe.load      = inValid;
    strobe.validNext = inValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= strobe.validNext;
  end

endmodule

// File: rtl/ipd_decode.sv
module ipd_decode
  import ipd_pkg::*;
#(
  parameter logic [CTRL_N-1:0] CTRL_POP = DEF_CTRL_POP,
  parameter logic [COBR_N-1:0] COBR_POP = DEF_COBR_POP,
  parameter logic [REG_N-1:0]  REG_POP  = DEF_REG_POP,
  parameter logic [MEM_N-1:0]  MEM_POP  = DEF_MEM_POP
)(
  input  logic [WORD_W-1:0] word,
  output decode_t           dec
);

  localparam int REG_IW = $clog2(REG_N);
  localparam logic [OPC_W-1:0] REG_LO_V = OPC_W'(REG_LO);
  localparam logic [OPC_W-1:0] REG_HI_V = OPC_W'(REG_HI);

  logic [7:0]        opByte;
  logic [OPC_W-1:0]  regOpc;
  logic [OPC_W-1:0]  regOff;
  logic              regInRange;
  logic              regPop;
  logic              memPop;
  logic [MODE_W-1:0] mode;
  fmt_e              fmt;

  always_comb begin
    opByte     = word[31:24];
    regOpc     = {opByte, word[10:7]};
    regOff     = regOpc - REG_LO_V;
    regInRange = (regOpc >= REG_LO_V) && (regOpc <= REG_HI_V);
    regPop     = regInRange && REG_POP[regOff[REG_IW-1:0]];
    memPop     = MEM_POP[word[30:24]];
    mode       = word[13:10];
    if (word[31])      fmt = FMT_MEM;
    else if (word[30]) fmt = FMT_REG;
    else if (word[29]) fmt = FMT_COBR;
    else               fmt = FMT_CTRL;
  end

  always_comb begin
    dec     = '0;
    dec.fmt = fmt;
    dec.opc = {opByte, 4'h0};
    unique case (fmt)
      FMT_CTRL: begin
        dec.bad  = word[0] | ~CTRL_POP[word[28:24]];
        dec.hint = word[1];
        dec.disp = {{8{word[23]}}, word[23:2], 2'b00};
      end
      FMT_COBR: begin
        dec.bad  = ~COBR_POP[word[28:24]];
        dec.hint = word[1];
        dec.src1 = word[23:19];
        dec.src2 = word[18:14];
        dec.m1   = word[13];
        dec.s2   = word[0];
        dec.disp = {{19{word[12]}}, word[12:2], 2'b00};
      end
      FMT_REG: begin
        dec.opc  = regOpc;
        dec.bad  = ~regPop;
        dec.src1 = word[4:0];
        dec.s1   = word[5];
        dec.s2   = word[6];
        dec.m1   = word[11];
        dec.m2   = word[12];
        dec.m3   = word[13];
        dec.src2 = word[18:14];
        dec.dst  = word[23:19];
      end
      FMT_MEM: begin
        dec.bad   = ~memPop | (mode == 4'd6);
        dec.len8  = memPop & ((mode == 4'd5) | (mode >= 4'd12));
        dec.mode  = mode;
        dec.short = ~mode[2];
        dec.offs  = mode[2] ? '0 : word[11:0];
        dec.src1  = word[4:0];
        dec.src2  = word[18:14];
        dec.dst   = word[23:19];
      end
      default: dec = '0;
    endcase
  end

endmodule

// File: rtl/ipd_datapath.sv
module ipd_datapath
  import ipd_pkg::*;
#(
  parameter logic [CTRL_N-1:0] CTRL_POP = DEF_CTRL_POP,
  parameter logic [COBR_N-1:0] COBR_POP = DEF_COBR_POP,
  parameter logic [REG_N-1:0]  REG_POP  = DEF_REG_POP,
  parameter logic [MEM_N-1:0]  MEM_POP  = DEF_MEM_POP
)(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [WORD_W-1:0] word,
  output decode_t           result
);

  decode_t nextDec;

  ipd_decode #(
    .CTRL_POP(CTRL_POP),
    .COBR_POP(COBR_POP),
    .REG_POP (REG_POP),
    .MEM_POP (MEM_POP)
  ) i_decode (
    .word(word),
    .dec (nextDec)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            result <= '0;
    else if (strobe.load) result <= nextDec;
  end

endmodule

// File: rtl/insn_predecode.sv
module insn_predecode
  import ipd_pkg::*;
#(
  parameter logic [CTRL_N-1:0] CTRL_POP = DEF_CTRL_POP,
  parameter logic [COBR_N-1:0] COBR_POP = DEF_COBR_POP,
  parameter logic [REG_N-1:0]  REG_POP  = DEF_REG_POP,
  parameter logic [MEM_N-1:0]  MEM_POP  = DEF_MEM_POP
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] inWord,
  output logic        outValid,
  output logic [1:0]  fmtClass,
  output logic        lengthIs8,
  output logic        invalid,
  output logic [11:0] opcode,
  output logic [4:0]  src1,
  output logic [4:0]  src2,
  output logic [4:0]  dst,
  output logic        litM1,
  output logic        litM2,
  output logic        litM3,
  output logic        specS1,
  output logic        specS2,
  output logic        hintNotTaken,
  output logic [3:0]  memMode,
  output logic        memShort,
  output logic [11:0] memOffset,
  output logic [31:0] brDisp
);

  strobe_t strobe;
  decode_t result;

  ipd_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  ipd_datapath #(
    .CTRL_POP(CTRL_POP),
    .COBR_POP(COBR_POP),
    .REG_POP (REG_POP),
    .MEM_POP (MEM_POP)
  ) i_datapath (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .word  (inWord),
    .result(result)
  );

  always_comb begin
    fmtClass     = result.fmt;
    lengthIs8    = result.len8;
    invalid      = result.bad;
    opcode       = result.opc;
    src1         = result.src1;
    src2         = result.src2;
    dst          = result.dst;
    litM1        = result.m1;
    litM2        = result.m2;
    litM3        = result.m3;
    specS1       = result.s1;
    specS2       = result.s2;
    hintNotTaken = result.hint;
    memMode      = result.mode;
    memShort     = result.short;
    memOffset    = result.offs;
    brDisp       = result.disp;
  end

endmodule

// File: rtl/ipd_checker.sv
module ipd_checker (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [31:0] inWord,
  input logic        outValid,
  input logic [1:0]  fmtClass,
  input logic        lengthIs8,
  input logic        invalid,
  input logic [11:0] opcode,
  input logic [4:0]  src1,
  input logic [4:0]  src2,
  input logic [4:0]  dst,
  input logic        litM1,
  input logic        litM2,
  input logic        litM3,
  input logic        specS1,
  input logic        specS2,
  input logic        hintNotTaken,
  input logic [3:0]  memMode,
  input logic        memShort,
  input logic [11:0] memOffset,
  input logic [31:0] brDisp
);

  assert_valid_follows_R11: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  assert_valid_drops_R11: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(fmtClass) && $stable(invalid) && $stable(lengthIs8)
                  && $stable(opcode) && $stable(brDisp)));

  assert_top_bit_mem_R1: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inWord[31]) |=> (fmtClass == 2'd3));

  assert_ctrl_bit0_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inWord[31:29] == 3'b000 && inWord[0]) |=> invalid);

  assert_len8_legal_mem_R6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && lengthIs8) |-> (fmtClass == 2'd3 && !invalid));

  assert_mode6_bad_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && fmtClass == 2'd3 && memMode == 4'd6) |-> invalid);

  assert_hint_only_branch_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && fmtClass[1]) |-> !hintNotTaken);

  assert_disp_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && fmtClass[1]) |-> (brDisp == 32'd0));

endmodule

bind insn_predecode ipd_checker i_ipdChecker (.*);

// File: tb/test_insn_predecode.sv
`timescale 1ns/1ps
module test_insn_predecode;

  localparam logic [31:0]  T_CTRL = 32'hF0F0_3C5A;
  localparam logic [31:0]  T_COBR = 32'h0FF0_A5C3;
  localparam logic [543:0] T_REG  = {17{32'hA5C3_F00F}};
  localparam logic [127:0] T_MEM  = {4{32'h3C3C_F0F1}};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [31:0] inWord = '0;
  logic outValid, lengthIs8, invalid, litM1, litM2, litM3, specS1, specS2;
  logic hintNotTaken, memShort;
  logic [1:0] fmtClass;
  logic [11:0] opcode, memOffset;
  logic [4:0] src1, src2, dst;
  logic [3:0] memMode;
  logic [31:0] brDisp;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  insn_predecode #(
    .CTRL_POP(T_CTRL), .COBR_POP(T_COBR), .REG_POP(T_REG), .MEM_POP(T_MEM)
  ) i_insn_predecode (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inWord(inWord),
    .outValid(outValid), .fmtClass(fmtClass), .lengthIs8(lengthIs8),
    .invalid(invalid), .opcode(opcode), .src1(src1), .src2(src2), .dst(dst),
    .litM1(litM1), .litM2(litM2), .litM3(litM3), .specS1(specS1),
    .specS2(specS2), .hintNotTaken(hintNotTaken), .memMode(memMode),
    .memShort(memShort), .memOffset(memOffset), .brDisp(brDisp)
  );

  logic [1:0]  eFmt;
  logic        eLen8, eBad, eM1, eM2, eM3, eS1, eS2, eHint, eShort;
  logic [11:0] eOpc, eOffs;
  logic [4:0]  eSrc1, eSrc2, eDst;
  logic [3:0]  eMode;
  logic [31:0] eDisp;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s word=%h actual=%h expected=%h", req, inWord, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] w);
    int nib, rOpc, mode;
    nib = int'(w[31:28]);
    eFmt = (nib >= 8) ? 2'd3 : (nib >= 4) ? 2'd2 : (nib >= 2) ? 2'd1 : 2'd0;
    eLen8 = 0; eBad = 0; eM1 = 0; eM2 = 0; eM3 = 0; eS1 = 0; eS2 = 0;
    eHint = 0; eShort = 0; eOffs = 0; eSrc1 = 0; eSrc2 = 0; eDst = 0;
    eMode = 0; eDisp = 0;
    eOpc = {w[31:24], 4'h0};
    case (eFmt)
      2'd0: begin
        eBad = w[0] || !T_CTRL[int'(w[28:24])];
        eHint = w[1];
        eDisp = 32'(signed'({w[23:2], 2'b00}));
      end
      2'd1: begin
        eBad = !T_COBR[int'(w[28:24])];
        eHint = w[1];
        eSrc1 = w[23:19]; eSrc2 = w[18:14]; eM1 = w[13]; eS2 = w[0];
        eDisp = 32'(signed'({w[12:2], 2'b00}));
      end
      2'd2: begin
        rOpc = int'(w[31:24]) * 16 + int'(w[10:7]);
        eOpc = 12'(rOpc);
        eBad = !((rOpc >= 'h580) && (rOpc <= 'h79F) && T_REG[rOpc - 'h580]);
        eSrc1 = w[4:0]; eS1 = w[5]; eS2 = w[6];
        eM1 = w[11]; eM2 = w[12]; eM3 = w[13];
        eSrc2 = w[18:14]; eDst = w[23:19];
      end
      default: begin
        mode = int'(w[13:10]);
        eMode = w[13:10];
        eBad = (mode == 6) || !T_MEM[int'(w[30:24])];
        eLen8 = T_MEM[int'(w[30:24])] && (mode == 5 || mode >= 12);
        eShort = (mode < 4) || (mode >= 8 && mode < 12);
        eOffs = eShort ? w[11:0] : 12'd0;
        eSrc1 = w[4:0]; eSrc2 = w[18:14]; eDst = w[23:19];
      end
    endcase
  endtask

  task automatic check_all(input logic expValid);
    string rf;
    rf = (eFmt == 2'd0) ? "R2" : (eFmt == 2'd1) ? "R3" : (eFmt == 2'd2) ? "R4" : "R7";
    chk(outValid == expValid, "R11 outValid", 32'(outValid), 32'(expValid));
    chk(fmtClass == eFmt, "R1 fmtClass", 32'(fmtClass), 32'(eFmt));
    chk(invalid == eBad, {rf, " invalid"}, 32'(invalid), 32'(eBad));
    chk(lengthIs8 == eLen8, "R6 lengthIs8", 32'(lengthIs8), 32'(eLen8));
    chk(opcode == eOpc, "R4 opcode", 32'(opcode), 32'(eOpc));
    chk({src1, src2, dst} == {eSrc1, eSrc2, eDst}, "R5 src1/src2/dst",
        32'({src1, src2, dst}), 32'({eSrc1, eSrc2, eDst}));
    chk({litM1, litM2, litM3, specS1, specS2} == {eM1, eM2, eM3, eS1, eS2},
        "R3 mode/spec flags", 32'({litM1, litM2, litM3, specS1, specS2}),
        32'({eM1, eM2, eM3, eS1, eS2}));
    chk({memMode, memShort, memOffset} == {eMode, eShort, eOffs}, "R8 memory fields",
        32'({memMode, memShort, memOffset}), 32'({eMode, eShort, eOffs}));
    chk(hintNotTaken == eHint, "R9 hint", 32'(hintNotTaken), 32'(eHint));
    chk(brDisp == eDisp, "R10 brDisp", brDisp, eDisp);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] lfsr;
    logic [31:0] w;
    int n;
    lfsr = 32'h1D2C_3B4A;
    n = 0;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(outValid == 1'b0, "R12 outValid", 32'(outValid), 32'd0);
    chk({fmtClass, invalid, lengthIs8, opcode, brDisp} == '0, "R12 results",
        32'({fmtClass, invalid, lengthIs8, opcode}) | brDisp, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(outValid == 1'b0, "R12 outValid after release", 32'(outValid), 32'd0);
    model(32'h0);
    for (int b = 0; b < 256; b++) begin
      for (int k = 0; k < 16; k++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        w = {8'(b), lfsr[23:0]};
        if (b >= 128) w[13:10] = 4'(k);
        else          w[10:7]  = 4'(k);
        inValid = 1'b1;
        inWord = w;
        @(negedge clk);
        model(w);
        check_all(1'b1);
        n++;
        if (n % 7 == 0) begin
          // R11: idle cycle, results must hold
          inValid = 1'b0;
          inWord = ~w;
          @(negedge clk);
          check_all(1'b0);
        end
      end
    end
    inValid = 1'b0;
    finish_run();
  end

endmodule